// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block lets a host processor read and write a bank of 16-bit control registers over an asynchronous parallel bus. The bus has a chip select, a read strobe and two byte-lane write strobes, one for the upper byte and one for the lower byte. A mode pin, sampled while reset is asserted, picks how the address arrives. In separate mode seven address pins give the word address directly. In multiplexed mode the host first puts the address on the low data byte and pulses the top address pin as an address-latch strobe. It then uses the same data pins to transfer the data.

All bus control inputs pass through two-flop synchronizers into the internal clock domain. Strobe edges are detected there. The address and data lines are brought in through a matching pipeline, so they line up with the synchronized strobes. The data bus is split into an input half and an output half. An output-enable signal drives an external tristate buffer. The register bank holds 64 words. The remaining word addresses read as zero and ignore writes.

Top module: `hostbus_regif`

## Requirements
- R1: The bus mode is taken from `bus_mode_i` while `rst_n` is low: 0 selects separate mode and 1 selects multiplexed mode. Changing `bus_mode_i` after reset has no effect on how later bus cycles are decoded.
- R2: In separate mode the word address is `addr_i[6:0]`, where bit 6 is the most significant address bit. The data is all 16 bits of `data_i` / `data_o`.
- R3: In multiplexed mode `addr_i[6]` is the address-latch strobe. The word address is `data_i[7:1]`, captured when the strobe falls while chip select is low. `data_i[0]` and `addr_i[5:0]` are ignored. The host holds the address for at least 3 clocks after the strobe falls.
- R4: A rising edge on `wr_hi_n_i` writes `data_i[15:8]` into the addressed register, and a rising edge on `wr_lo_n_i` writes `data_i[7:0]`. A byte lane whose strobe did not rise keeps its old value. The write takes effect within 3 clocks of the rising edge. Chip select, address and data stay valid for at least 3 clocks after that edge.
- R5: While `cs_n_i` and `rd_n_i` are both low, `data_oe_o` goes high and `data_o` shows the addressed register, within 4 clocks. Otherwise `data_oe_o` is low and `data_o` is zero.
- R6: While `cs_n_i` is high, no write takes place, no address is latched and `data_oe_o` stays low.
- R7: Reset clears every register to zero.
- R8: Word addresses 64 to 127 read as zero, and writes to them are discarded without changing any implemented register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset; the bus mode is sampled while it is low |
| bus_mode_i | input | 1 | 0 = separate address/data, 1 = multiplexed |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_hi_n_i | input | 1 | Active-low upper-byte write strobe, acts on its rising edge |
| wr_lo_n_i | input | 1 | Active-low lower-byte write strobe, acts on its rising edge |
| addr_i | input | 7 | Word address in separate mode; bit 6 is the address-latch strobe in multiplexed mode |
| data_i | input | 16 | Data in; bits 7:1 carry the address in the multiplexed address phase |
| data_o | output | 16 | Read data, zero when not enabled |
| data_oe_o | output | 1 | Output enable for an external tristate buffer |

## Verification
Both bus modes go through a full sweep of all 128 word addresses. Each word is written with a value computed from its address and then read back in ascending order. This shows that the upper half reads zero, and that no write to the upper half aliases onto an implemented word. In multiplexed mode the ignored pins carry values that change with the address, so decoding them by mistake would give wrong read data. Writes to a single byte lane, writes and reads attempted with chip select high, and a mode-pin change after reset each tell lane isolation, select gating and mode capture apart from the normal path.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic {
      BUS_SEPARATE = 1'b0,
      BUS_MUXED    = 1'b1
   } bus_mode_e;

   // synchronized control bundle, all active-low except the latch strobe
   typedef struct packed {
      logic ale;
      logic wr_lo_n;
      logic wr_hi_n;
      logic rd_n;
      logic cs_n;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '{ale: 1'b0, wr_lo_n: 1'b1, wr_hi_n: 1'b1,
                                   rd_n: 1'b1, cs_n: 1'b1};

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hbr_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hbr_addr_capture.sv
module hbr_addr_capture #(
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              muxed_i,
   input  logic              ale_fall_i,
   input  logic [ADDR_W-1:0] ad_i,
   input  logic [ADDR_W-1:0] sep_addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] latched;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          latched <= '0;
      else if (ale_fall_i) latched <= ad_i;
   end

   assign addr_o = muxed_i ? latched : sep_addr_i;

   // R3: a captured address stays put until the next latch-strobe fall
   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_fall_i |=> $stable(latched));

endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank #(
   parameter int unsigned NUM_WORDS = 64,
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DATA_W/8-1:0]    wr_be_i,
   input  logic [ADDR_W-1:0]      wr_addr_i,
   input  logic [DATA_W-1:0]      wr_data_i,
   input  logic [ADDR_W-1:0]      rd_addr_i,
   output logic [DATA_W-1:0]      rd_data_o
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("hbr_regbank: DATA_W must be a whole number of bytes");
      end
      if ((1 << IDX_W) != NUM_WORDS) begin : g_bad_depth
         $error("hbr_regbank: NUM_WORDS must be a power of two");
      end
      if (NUM_WORDS > (1 << ADDR_W)) begin : g_bad_span
         $error("hbr_regbank: NUM_WORDS exceeds the address space");
      end
   endgenerate

   logic [NUM_WORDS-1:0][DATA_W-1:0] mem;
   logic                             wr_in_range, rd_in_range;
   logic [IDX_W-1:0]                 wr_idx, rd_idx;

   assign wr_in_range = ({1'b0, wr_addr_i} < (ADDR_W+1)'(NUM_WORDS));
   assign rd_in_range = ({1'b0, rd_addr_i} < (ADDR_W+1)'(NUM_WORDS));
   assign wr_idx      = wr_addr_i[IDX_W-1:0];
   assign rd_idx      = rd_addr_i[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (wr_in_range) begin
         for (int ln = 0; ln < LANES; ln++) begin
            if (wr_be_i[ln]) mem[wr_idx][ln*8 +: 8] <= wr_data_i[ln*8 +: 8];
         end
      end
   end

   assign rd_data_o = rd_in_range ? mem[rd_idx] : '0;

   // R8: writes outside the implemented window leave the whole bank alone
   assert_unimpl_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_in_range) |=> $stable(mem));

   // R4: a lane whose strobe did not fire keeps its byte
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
         assert_lane_isolation_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_be_i[g] && wr_in_range) |=>
               mem[$past(wr_idx)][g*8 +: 8] == $past(mem[wr_idx][g*8 +: 8]));
      end
   endgenerate

endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_WORDS   = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mode_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              wr_hi_n_i,
   input  logic              wr_lo_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o
);
   import hbr_pkg::*;

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned PIPE_W = ADDR_W + DATA_W;

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("hostbus_regif: two byte strobes require DATA_W == 16");
      end
      if (ADDR_W + 1 > 8) begin : g_bad_addr
         $error("hostbus_regif: muxed address must fit in the low data byte");
      end
   endgenerate

   // mode is frozen while reset is held
   bus_mode_e mode_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= bus_mode_e'(bus_mode_i);
   end

   // control synchronizers plus one delay stage for edge detection
   ctrl_t ctrl_raw, ctrl_s, ctrl_d;
   assign ctrl_raw = '{ale: addr_i[ADDR_W-1], wr_lo_n: wr_lo_n_i, wr_hi_n: wr_hi_n_i,
                       rd_n: rd_n_i, cs_n: cs_n_i};

   hbr_sync #(.W($bits(ctrl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_d <= CTRL_IDLE;
      else        ctrl_d <= ctrl_s;
   end

   // address and data pipelined to match the control latency
   logic [PIPE_W-1:0] bus_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] data_s;

   hbr_sync #(.W(PIPE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_pipe (
      .clk(clk), .rst_n(rst_n), .d({addr_i, data_i}), .q(bus_s));

   assign {addr_s, data_s} = bus_s;

   // edge detection, gated by the synchronized chip select
   logic              sel;
   logic              ale_fall;
   logic [LANES-1:0]  wr_be;
   logic [ADDR_W-1:0] word_addr;

   assign sel      = !ctrl_s.cs_n;
   assign ale_fall = (mode_q == BUS_MUXED) && sel && ctrl_d.ale && !ctrl_s.ale;
   assign wr_be[1] = sel && !ctrl_d.wr_hi_n && ctrl_s.wr_hi_n;
   assign wr_be[0] = sel && !ctrl_d.wr_lo_n && ctrl_s.wr_lo_n;

   hbr_addr_capture #(.ADDR_W(ADDR_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .muxed_i    (mode_q == BUS_MUXED),
      .ale_fall_i (ale_fall),
      .ad_i       (data_s[ADDR_W:1]),
      .sep_addr_i (addr_s),
      .addr_o     (word_addr));

   logic [DATA_W-1:0] rd_data;

   hbr_regbank #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_be_i   (wr_be),
      .wr_addr_i (word_addr),
      .wr_data_i (data_s),
      .rd_addr_i (word_addr),
      .rd_data_o (rd_data));

   // registered read path, enable and data aligned
   logic rd_act;
   assign rd_act = sel && !ctrl_s.rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o    <= '0;
         data_oe_o <= 1'b0;
      end else begin
         data_o    <= rd_act ? rd_data : '0;
         data_oe_o <= rd_act;
      end
   end

   // R5: an undriven bus presents zero
   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe_o |-> (data_o == '0));

   generate
      if (SYNC_STAGES == 2) begin : g_port_chk
         // R5: enable only follows a select-and-read seen three edges earlier
         assert_oe_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
            data_oe_o |-> (!$past(cs_n_i, 3) && !$past(rd_n_i, 3)));
         // R6: a write commit needs chip select low two edges earlier
         assert_write_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_be != '0) |-> !$past(cs_n_i, 2));
      end
   endgenerate

endmodule

// File: tb/sim_hostbus_regif.sv
module sim_hostbus_regif;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_mode = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_hi_n = 1'b1, wr_lo_n = 1'b1;
   logic [6:0]  addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic        oe;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hostbus_regif u0 (
      .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .cs_n_i(cs_n), .rd_n_i(rd_n),
      .wr_hi_n_i(wr_hi_n), .wr_lo_n_i(wr_lo_n), .addr_i(addr), .data_i(din),
      .data_o(dout), .data_oe_o(oe));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int a, input logic [15:0] salt);
      return 16'((a * 16'h0123) ^ salt) + 16'(a);
   endfunction

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; bus_mode = mode;
      cs_n = 1'b1; rd_n = 1'b1; wr_hi_n = 1'b1; wr_lo_n = 1'b1; addr = '0; din = '0;
      clocks(3);
      rst_n = 1'b1;
      clocks(3);
   endtask

   // address phase for muxed mode: junk on ignored pins
   task automatic mux_addr(input logic [6:0] a);
      addr = {1'b1, ~a[5:0]};
      din  = {8'hA5, a, ~a[0]};
      clocks(3);
      addr[6] = 1'b0;
      clocks(3);
   endtask

   task automatic bus_write(input logic muxed, input logic [6:0] a, input logic [15:0] d,
                            input logic hi, input logic lo, input logic sel);
      @(negedge clk);
      cs_n = !sel;
      if (muxed) mux_addr(a);
      else addr = a;
      din = d;
      clocks(1);
      wr_hi_n = !hi; wr_lo_n = !lo;
      clocks(3);
      wr_hi_n = 1'b1; wr_lo_n = 1'b1;
      clocks(3);
      cs_n = 1'b1;
      clocks(2);
   endtask

   task automatic bus_read(input logic muxed, input logic [6:0] a, input logic sel,
                           output logic [15:0] v, output logic e);
      @(negedge clk);
      cs_n = !sel;
      if (muxed) mux_addr(a);
      else addr = a;
      din = 16'h3C3C;
      rd_n = 1'b0;
      clocks(4);
      v = dout; e = oe;
      rd_n = 1'b1; cs_n = 1'b1;
      clocks(3);
   endtask

   task automatic sweep(input logic muxed, input logic [15:0] salt, input string req);
      logic [15:0] v;
      logic e;
      for (int a = 0; a < 128; a++) bus_write(muxed, 7'(a), pat(a, salt), 1'b1, 1'b1, 1'b1);
      for (int a = 0; a < 128; a++) begin
         bus_read(muxed, 7'(a), 1'b1, v, e);
         // R8: upper half reads zero and never aliases downward
         check({req, " R8"}, v, (a < 64) ? pat(a, salt) : 16'h0000);
         check({req, " R5 oe"}, {15'b0, e}, 16'h0001);
      end
   endtask

   initial begin
      logic [15:0] v;
      logic e;

      // separate mode
      do_reset(1'b0);
      check("R7 oe after reset", {15'b0, oe}, 16'h0000);
      check("R5 idle data", dout, 16'h0000);
      for (int a = 0; a < 64; a += 21) begin
         bus_read(1'b0, 7'(a), 1'b1, v, e);
         check("R7 reset value", v, 16'h0000);
      end
      clocks(1);
      check("R5 oe released", {15'b0, oe}, 16'h0000);
      check("R5 data released", dout, 16'h0000);

      sweep(1'b0, 16'h5A3C, "R2 separate");

      // byte lanes
      bus_write(1'b0, 7'd10, 16'h1234, 1'b0, 1'b1, 1'b1);
      bus_read(1'b0, 7'd10, 1'b1, v, e);
      check("R4 low lane only", v, {pat(10, 16'h5A3C)[15:8], 8'h34});
      bus_write(1'b0, 7'd10, 16'hABCD, 1'b1, 1'b0, 1'b1);
      bus_read(1'b0, 7'd10, 1'b1, v, e);
      check("R4 high lane only", v, 16'hAB34);

      // chip select high
      bus_write(1'b0, 7'd3, 16'hDEAD, 1'b1, 1'b1, 1'b0);
      bus_read(1'b0, 7'd3, 1'b0, v, e);
      check("R6 oe with cs high", {15'b0, e}, 16'h0000);
      check("R6 data with cs high", v, 16'h0000);
      bus_read(1'b0, 7'd3, 1'b1, v, e);
      check("R6 write ignored", v, pat(3, 16'h5A3C));

      // mode pin change after reset
      bus_mode = 1'b1;
      bus_write(1'b0, 7'd20, 16'h0F0F, 1'b1, 1'b1, 1'b1);
      bus_read(1'b0, 7'd20, 1'b1, v, e);
      check("R1 separate kept", v, 16'h0F0F);

      // multiplexed mode
      do_reset(1'b1);
      bus_read(1'b1, 7'd10, 1'b1, v, e);
      check("R7 reset after mode switch", v, 16'h0000);
      sweep(1'b1, 16'hC3A5, "R3 muxed");

      bus_write(1'b1, 7'd33, 16'h7788, 1'b0, 1'b1, 1'b1);
      bus_read(1'b1, 7'd33, 1'b1, v, e);
      check("R4 muxed low lane", v, {pat(33, 16'hC3A5)[15:8], 8'h88});

      bus_write(1'b1, 7'd40, 16'hBEEF, 1'b1, 1'b1, 1'b0);
      bus_read(1'b1, 7'd40, 1'b1, v, e);
      check("R6 muxed write ignored", v, pat(40, 16'hC3A5));

      bus_mode = 1'b0;
      bus_write(1'b1, 7'd50, 16'h4242, 1'b1, 1'b1, 1'b1);
      bus_read(1'b1, 7'd50, 1'b1, v, e);
      check("R1 muxed kept", v, 16'h4242);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule